// File: doc/BRIEF.md
# Optical Serial Transmit Modulator

This block shapes the transmit signal of an infrared serial port. The optical pin can take its serial data from a hardware UART transmitter or from a general-purpose output bit that software toggles. In the second case the UART transmit line is sent to a secondary pin instead. A two-bit selector picks the optical pin's source from four candidates: the plain serial path, the serial path forced onto the carrier, a variable-pulse signal and a watt-pulse signal. The chosen signal can be gated onto a carrier of about 38 kHz with a programmable high fraction, and it can be inverted.

The carrier is a free-running counter of `CAR_PERIOD` clocks. With 129 counts it gives 38.1 kHz from a 4.9152 MHz clock. A single 8-bit control word is written through a one-cycle write strobe into a shadow register. The shadow is copied into the working configuration only when the carrier counter wraps, so a change never cuts a carrier pulse short. The block also returns the optical receive input to the UART, with an option to block it.

Top module: `optx_modulator`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `opt_txd`, `alt_txd` and `uart_rxd` are all 1. The working configuration resets to 0x00.
- R2: Control bit 0 selects the serial source. When it is 1, the serial source is `gpio_bit` and `alt_txd` follows `uart_txd`. When it is 0, the serial source is `uart_txd` and `alt_txd` is held at 1.
- R3: Control bits [2:1] pick the optical source: 0 = serial source, 1 = serial source on the carrier (always modulated), 2 = `var_pulse`, 3 = `watt_pulse`.
- R4: The carrier counter runs from 0 to `CAR_PERIOD`-1 and wraps, so one carrier period is `CAR_PERIOD` clocks (129 by default).
- R5: Control bits [5:4] set the carrier on-time to `CAR_PERIOD >> (4 - code)` clocks at the start of each period. With the default period this is 8, 16, 32 or 64 clocks.
- R6: When modulation is applied (bit 3 set, or source 1), a source level of 0 drives the pre-inversion output to 0 during the carrier on-time and to 1 for the rest of the period. A source level of 1 gives a steady 1.
- R7: With bit 3 clear and source 0, 2 or 3, the selected level passes through unmodulated.
- R8: Control bit 6 inverts the optical output after the source selection and the modulation.
- R9: When control bit 7 is 1, `uart_rxd` is held at 1. Otherwise `uart_rxd` follows `opt_rxd`.
- R10: A value written with `cfg_wr` takes effect on the clock edge where the carrier counter wraps from `CAR_PERIOD`-1 to 0. Before that edge, the outputs keep following the previous configuration.
- R11: `opt_txd`, `alt_txd` and `uart_rxd` are registered. Each reflects the inputs and the working configuration from one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word: [0] bit-bang, [2:1] source, [3] modulate, [5:4] duty, [6] invert, [7] receive off |
| uart_txd | input | 1 | UART transmit data |
| gpio_bit | input | 1 | Software-driven output bit |
| var_pulse | input | 1 | Variable-pulse source |
| watt_pulse | input | 1 | Watt-pulse source |
| opt_rxd | input | 1 | Optical receiver input |
| opt_txd | output | 1 | Optical transmit pin |
| alt_txd | output | 1 | Secondary pin carrying UART transmit data in bit-bang mode |
| uart_rxd | output | 1 | Receive data to the UART |

## Verification
A carrier counter that is out of phase, or one that wraps at the wrong count, makes the low bursts on `opt_txd` begin at the wrong clock. It also makes a control write take effect at the wrong edge. Either shows at the pin within one carrier period of 129 clocks. A wrong working-configuration register shows on the next clock at the pin it controls: a wrong source, polarity or receive gate, or `alt_txd` following `uart_txd` when it should not. A wrong duty code shows as a wrong count of low cycles in the first modulated period.

// File: rtl/optx_pkg.sv
// Shared types for the optical transmit modulator.
// Assumes the control word layout below is fixed; bit 0 is the LSB.
package optx_pkg;

    typedef struct packed {
        logic       rx_off;  // [7] block optical receive
        logic       tx_inv;  // [6] invert optical output
        logic [1:0] duty;    // [5:4] carrier on-time code
        logic       mod_en;  // [3] apply carrier
        logic [1:0] src;     // [2:1] optical source select
        logic       bb;      // [0] bit-bang serial source
    } optx_cfg_t;

    localparam int unsigned CFG_W = $bits(optx_cfg_t);

    // Carrier on-time in clocks for a duty code: period >> (4 - code).
    function automatic int unsigned optx_on_len(int unsigned period, logic [1:0] code);
        return period >> (4 - int'(code));
    endfunction

endpackage

// File: rtl/optx_carrier.sv
// Carrier generator: free-running period counter with wrap strobe and
// on-time flag. Assumes CAR_PERIOD >= 16 so every duty code gives a
// non-zero on-time that starts at count 0.
module optx_carrier
    import optx_pkg::*;
#(
    parameter int unsigned CAR_PERIOD = 129,
    localparam int unsigned CW = $clog2(CAR_PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    duty,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          car_on
);

    localparam logic [CW-1:0] LAST = CW'(CAR_PERIOD - 1);

    logic [CW:0] on_len;

    // Wrap strobe marks the final count of a period.
    assign wrap = (cnt == LAST);

    // On-time length for the current duty code.
    always_comb on_len = (CW+1)'(optx_on_len(CAR_PERIOD, duty));

    // Carrier is on for the first on_len counts of a period.
    assign car_on = ({1'b0, cnt} < on_len);

    // Period counter: counts up and wraps at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (cnt == $past(cnt) + 1'b1));
    // R5
    on_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> car_on);

endmodule

// File: rtl/optx_cfg.sv
// Control register pair: a shadow written by software and a working
// copy loaded only on the carrier wrap. Assumes a single write port.
module optx_cfg
    import optx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             load,
    output optx_cfg_t        act
);

    optx_cfg_t shadow;

    // Shadow register captures every software write.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow <= '0;
        else if (wr) shadow <= optx_cfg_t'(wdata);
    end

    // Working configuration follows the shadow at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= '0;
        else if (load) act <= shadow;
    end

    // R10
    hold_between_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act));

endmodule

// File: rtl/optx_path.sv
// Data path: serial source swap, four-way source select, carrier gating,
// inversion and output registers. Assumes inputs are already synchronous.
module optx_path
    import optx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  optx_cfg_t act,
    input  logic      car_on,
    input  logic      uart_txd,
    input  logic      gpio_bit,
    input  logic      var_pulse,
    input  logic      watt_pulse,
    input  logic      opt_rxd,
    output logic      opt_txd,
    output logic      alt_txd,
    output logic      uart_rxd
);

    logic serial, gated, picked, shaped;

    // Serial source swap and the carrier-gated copy of it.
    always_comb begin
        serial = act.bb ? gpio_bit : uart_txd;
        gated  = serial | ~car_on;
    end

    // Four-way source select, optional carrier, then polarity.
    always_comb begin
        unique case (act.src)
            2'd0:    picked = serial;
            2'd1:    picked = gated;
            2'd2:    picked = var_pulse;
            default: picked = watt_pulse;
        endcase
        shaped = act.mod_en ? (picked | ~car_on) : picked;
    end

    // Output registers; idle high during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_txd  <= 1'b1;
            alt_txd  <= 1'b1;
            uart_rxd <= 1'b1;
        end else begin
            opt_txd  <= shaped ^ act.tx_inv;
            alt_txd  <= act.bb ? uart_txd : 1'b1;
            uart_rxd <= act.rx_off ? 1'b1 : opt_rxd;
        end
    end

    // R9
    rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act.rx_off |=> uart_rxd);
    // R2
    alt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act.bb |=> (alt_txd == $past(uart_txd)));
    // R6
    idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!car_on && !act.tx_inv && (act.mod_en || act.src == 2'd1)) |=> opt_txd);

endmodule

// File: rtl/optx_modulator.sv
// Top level of the optical serial transmit modulator. Ties together the
// control registers, carrier generator and data path. Assumes all inputs
// are synchronous to clk.
module optx_modulator
    import optx_pkg::*;
#(
    parameter int unsigned CAR_PERIOD = 129,
    localparam int unsigned CW = $clog2(CAR_PERIOD)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic       uart_txd,
    input  logic       gpio_bit,
    input  logic       var_pulse,
    input  logic       watt_pulse,
    input  logic       opt_rxd,
    output logic       opt_txd,
    output logic       alt_txd,
    output logic       uart_rxd
);

    optx_cfg_t     act;
    logic [CW-1:0] cnt;
    logic          wrap, car_on;

    optx_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .load  (wrap),
        .act   (act)
    );

    optx_carrier #(.CAR_PERIOD(CAR_PERIOD)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty   (act.duty),
        .cnt    (cnt),
        .wrap   (wrap),
        .car_on (car_on)
    );

    optx_path u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .car_on     (car_on),
        .uart_txd   (uart_txd),
        .gpio_bit   (gpio_bit),
        .var_pulse  (var_pulse),
        .watt_pulse (watt_pulse),
        .opt_rxd    (opt_rxd),
        .opt_txd    (opt_txd),
        .alt_txd    (alt_txd),
        .uart_rxd   (uart_rxd)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (opt_txd && alt_txd && uart_rxd));

endmodule

// File: tb/tb_optx_modulator.sv
// Bench: a cycle model built from the requirements, random stimulus and
// control writes, plus directed carrier, duty and boundary cases.
module tb_optx_modulator;

    localparam int P = 129;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic uart_txd = 1'b1, gpio_bit = 1'b1, var_pulse = 1'b0, watt_pulse = 1'b0, opt_rxd = 1'b1;
    logic opt_txd, alt_txd, uart_rxd;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    optx_modulator dut (.*);

    // Model state: period count, shadow, working config, expected outputs.
    int m_cnt;
    logic [7:0] m_sh, m_act;
    logic e_tx, e_alt, e_rx;

    function automatic int on_len(logic [1:0] d);
        case (d) 2'd0: return 8; 2'd1: return 16; 2'd2: return 32; default: return 64; endcase
    endfunction

    function automatic logic f_tx(logic [7:0] c, int k, logic u, logic g, logic v, logic w);
        logic s, p;
        logic on;
        on = (k < on_len(c[5:4]));
        s = c[0] ? g : u;
        case (c[2:1]) 2'd0: p = s; 2'd1: p = s | ~on; 2'd2: p = v; default: p = w; endcase
        if (c[3]) p = p | ~on;
        return p ^ c[6];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_sh <= '0; m_act <= '0;
            e_tx <= 1'b1; e_alt <= 1'b1; e_rx <= 1'b1;
        end else begin
            e_tx  <= f_tx(m_act, m_cnt, uart_txd, gpio_bit, var_pulse, watt_pulse);
            e_alt <= m_act[0] ? uart_txd : 1'b1;
            e_rx  <= m_act[7] ? 1'b1 : opt_rxd;
            if (cfg_wr) m_sh <= cfg_wdata;
            if (m_cnt == P-1) begin m_cnt <= 0; m_act <= m_sh; end
            else m_cnt <= m_cnt + 1;
        end
    end

    task automatic check(logic act, logic exp, string tag, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model; tag by the mode in force.
    task automatic cmp_all();
        string t;
        if (m_act[3] || m_act[2:1] == 2'd1) t = "R6";
        else if (m_act[6]) t = "R8";
        else if (m_act[2:1] != 2'd0) t = "R3";
        else t = "R7";
        check(opt_txd, e_tx, t, "opt_txd");
        check(alt_txd, e_alt, "R2", "alt_txd");
        check(uart_rxd, e_rx, "R9", "uart_rxd");
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_all();
            cfg_wr = 1'b0;
        end
    endtask

    task automatic write_cfg(logic [7:0] v);
        @(negedge clk); cmp_all();
        cfg_wr = 1'b1; cfg_wdata = v;
        step(1);
    endtask

    // Bring the model counter to a value, then wait a full period so the
    // shadow is in force.
    task automatic apply_cfg(logic [7:0] v);
        write_cfg(v);
        while (m_cnt != 0) step(1);
        step(P);
        while (m_cnt != 0) step(1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(opt_txd, 1'b1, "R1", "opt_txd in reset");
        check(alt_txd, 1'b1, "R1", "alt_txd in reset");
        check(uart_rxd, 1'b1, "R1", "uart_rxd in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(opt_txd, 1'b1, "R1", "opt_txd after reset");
        check(alt_txd, 1'b1, "R1", "alt_txd after reset");

        // R11: one-clock latency on the plain serial path
        uart_txd = 1'b0;
        @(negedge clk);
        check(opt_txd, 1'b0, "R11", "opt_txd one clock after uart_txd fell");
        uart_txd = 1'b1;
        step(1);

        // R4, R5: period and on-time for each duty code, source 0 modulated
        for (int d = 0; d < 4; d++) begin
            int lows, first, second;
            apply_cfg(8'h08 | 8'(d << 4));
            uart_txd = 1'b0;
            step(2);
            lows = 0; first = -1; second = -1;
            for (int k = 0; k < 2*P; k++) begin
                logic prev;
                prev = opt_txd;
                step(1);
                if (k < P && opt_txd == 1'b0) lows++;
                if (prev && !opt_txd) begin
                    if (first < 0) first = k; else if (second < 0) second = k;
                end
            end
            checks++;
            if (lows != on_len(2'(d))) begin errors++;
                $display("FAIL R5 low count duty=%0d: actual=%0d expected=%0d", d, lows, on_len(2'(d))); end
            checks++;
            if (second - first != P) begin errors++;
                $display("FAIL R4 period: actual=%0d expected=%0d", second - first, P); end
            uart_txd = 1'b1;
        end

        // R10: write inversion mid-period; pin holds until the wrap edge
        apply_cfg(8'h00);
        uart_txd = 1'b1;
        while (m_cnt != 5) step(1);
        write_cfg(8'h40);
        while (m_cnt != 0) begin
            step(1);
            if (m_cnt != 0) check(opt_txd, 1'b1, "R10", "opt_txd before wrap");
        end
        step(1);
        check(opt_txd, 1'b0, "R10", "opt_txd after wrap (inverted)");

        // R2, R3, R8, R9 directed: bit-bang, watt source, receive block
        apply_cfg(8'h01);
        gpio_bit = 1'b0; uart_txd = 1'b1; step(1);
        check(opt_txd, 1'b0, "R2", "opt_txd from gpio_bit");
        check(alt_txd, 1'b1, "R2", "alt_txd from uart_txd");
        apply_cfg(8'h86);
        watt_pulse = 1'b1; opt_rxd = 1'b0; step(1);
        check(opt_txd, 1'b1, "R3", "opt_txd from watt_pulse");
        check(uart_rxd, 1'b1, "R9", "uart_rxd blocked");

        // Random phase: random inputs and occasional control writes
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            cmp_all();
            cfg_wr = 1'b0;
            if (($urandom % 4) == 0) begin
                uart_txd = 1'($urandom); gpio_bit = 1'($urandom);
                var_pulse = 1'($urandom); watt_pulse = 1'($urandom); opt_rxd = 1'($urandom);
            end
            if (($urandom % 300) == 0) begin
                cfg_wr = 1'b1; cfg_wdata = 8'($urandom);
            end
        end
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule